// File: doc/BRIEF.md
# Interrupt Cause Register with First-Source Capture

This block holds the interrupt cause of a bus target interface. It watches fourteen single-cycle event strobes from the surrounding interface logic, such as abort, parity and timeout events. It also watches one event that it generates itself: a target-abort, raised when an I/O access arrives with byte enables that do not fit the low two address bits. The status register keeps only the first cause that shows up. The cause is recorded whether or not its enable bit is set. An interrupt request is raised only when the recorded cause is enabled.

Software reaches the block through a one-bit register select. Select 0 reads the status word and clears its bits by writing ones. Select 1 reads and writes the enable mask. Both words are 32 bits wide, and bits 31 down to 15 are always zero. Bits 13 down to 0 hold the external events, with event input n at bit n. Bit 14 holds the target-abort cause.

Top module: `irq_cause_top`

## Requirements
- R1: After reset, the status word, the enable word and `irq_o` are all 0.
- R2: While any status bit is set, no new event is recorded. The status word keeps its value until software clears it.
- R3: If the status word is empty and several causes fire in the same cycle, only the lowest-numbered one is recorded. At all times, at most one status bit is set.
- R4: A cause whose enable bit is 0 still sets its status bit, but `irq_o` stays low.
- R5: `irq_o` is registered. It goes high one cycle after (status AND enable) becomes nonzero, and low one cycle after it becomes zero.
- R6: A write with select 0 clears every status bit written with 1. Bits written with 0 keep their value.
- R7: If a status clear and a new cause happen in the same cycle, and the clear leaves the status word empty, the new cause is recorded.
- R8: Bits 31 down to 15 read as 0 for both selects. Writes to these bits have no effect.
- R9: An I/O access with address bits [1:0] = 00 never raises the target-abort cause (status bit 14), whatever the byte enables (`io_be_i` bit k = 1 means lane k is enabled).
- R10: An I/O access with address bits [1:0] = a, where a is 1, 2 or 3, raises status bit 14 unless lane a is enabled and every lane below a is disabled. When `io_acc_i` is low, no target-abort is raised.
- R11: A write with select 1 loads bits 14 down to 0 of the write data into the enable word. A read with select 1 returns the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 14 | External cause strobes; bit n goes to status bit n |
| io_acc_i | input | 1 | An I/O target access is being decoded this cycle |
| io_addr_i | input | 2 | Low address bits of that access |
| io_be_i | input | 4 | Byte-lane enables of that access, 1 = lane enabled |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 = status, 1 = enable |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check four properties on every cycle:
- at most one status bit is set, and the status word holds steady unless software clears it;
- the interrupt stays low in the cycle after status AND enable is zero;
- an access with address 00 never produces a target-abort;
- the reserved read bits are zero.

Other behaviours can only be seen through sequences in the bench scenarios:
- which cause wins when causes arrive together;
- that a masked cause is still recorded;
- the ones-only clear;
- a clear that coincides with a new cause;
- the full byte-enable legality rule for the nonzero addresses.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned EXT_EVT_N = 14;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned LANE_N    = 4;
  localparam int unsigned LADDR_W   = 2;

  typedef enum logic {
    SEL_CAUSE = 1'b0,
    SEL_MASK  = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/irq_be_check.sv
module irq_be_check #(
  parameter int unsigned LANES = 4,
  parameter int unsigned AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  output logic             abort_o
);
  logic [LANES-1:0] below_mask;
  logic             lower_clear;
  logic             lane_hit;
  logic             legal;

  always_comb begin
    below_mask = '0;
    for (int k = 0; k < LANES; k++) begin
      if (k < int'(addr_i)) below_mask[k] = 1'b1;
    end
  end

  assign lower_clear = (be_i & below_mask) == '0;
  assign lane_hit    = be_i[addr_i];
  assign legal       = (addr_i == '0) || (lane_hit && lower_clear);
  assign abort_o     = acc_i && !legal;

  // R9
  addr_zero_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && addr_i == '0) |-> !abort_o);

  // R10
  idle_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |-> !abort_o);
endmodule

// File: rtl/irq_first_capture.sv
module irq_first_capture #(
  parameter int unsigned STAT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] ev_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W:0]   seen_lower;
  logic [STAT_W-1:0] winner;
  logic [STAT_W-1:0] kept;
  logic [STAT_W-1:0] status_d;
  logic [STAT_W-1:0] status_q;
  logic              status_en;
  logic              ev_any;

  assign seen_lower[0] = 1'b0;
  for (genvar i = 0; i < STAT_W; i++) begin : g_prio
    assign winner[i]       = ev_i[i] & ~seen_lower[i];
    assign seen_lower[i+1] = seen_lower[i] | ev_i[i];
  end
  assign ev_any = seen_lower[STAT_W];

  always_comb begin
    kept     = status_q & ~clr_i;
    status_d = kept;
    if (kept == '0 && ev_any) status_d = winner;
    status_en = (clr_i != '0) || (kept == '0 && ev_any);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  assign status_o = status_q;

  // R3
  single_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q));

  // R2
  hold_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != '0 && clr_i == '0) |=> $stable(status_q));

  // R7
  capture_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~clr_i) == '0 && ev_i != '0) |=> $countones(status_q) == 1);
endmodule

// File: rtl/irq_mask_gen.sv
module irq_mask_gen #(
  parameter int unsigned STAT_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we_i,
  input  logic [STAT_W-1:0] mask_d_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [STAT_W-1:0] mask_o,
  output logic              irq_o
);
  logic [STAT_W-1:0] mask_q;
  logic              irq_d;
  logic              irq_q;

  always_comb begin
    irq_d = |(status_i & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_we_i) mask_q <= mask_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i & mask_q) == '0) |=> !irq_o);

  // R5
  irq_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(status_i != '0));
endmodule

// File: rtl/irq_cause_top.sv
module irq_cause_top
  import irq_cause_pkg::*;
#(
  parameter int unsigned EVT_N  = EXT_EVT_N,
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              io_acc_i,
  input  logic [1:0]        io_addr_i,
  input  logic [3:0]        io_be_i,
  input  logic              reg_wr_i,
  input  logic              reg_sel_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned STAT_W = EVT_N + 1;

  logic              srst_n;
  logic              ta_ev;
  logic [STAT_W-1:0] cause_ev;
  logic [STAT_W-1:0] clr_bits;
  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] mask;
  logic              mask_we;
  reg_sel_e          sel;
  logic              unused_hi;

  assign sel       = reg_sel_e'(reg_sel_i);
  assign unused_hi = ^reg_wdata_i[DATA_W-1:STAT_W];

  irq_rst_sync u_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  irq_be_check #(.LANES(LANE_N), .AW(LADDR_W)) u_be (
    .clk     (clk),
    .rst_n   (srst_n),
    .acc_i   (io_acc_i),
    .addr_i  (io_addr_i),
    .be_i    (io_be_i),
    .abort_o (ta_ev)
  );

  assign cause_ev = {ta_ev, evt_i};

  always_comb begin
    clr_bits = '0;
    if (reg_wr_i && sel == SEL_CAUSE) clr_bits = reg_wdata_i[STAT_W-1:0];
    mask_we  = reg_wr_i && sel == SEL_MASK;
  end

  irq_first_capture #(.STAT_W(STAT_W)) u_cap (
    .clk      (clk),
    .rst_n    (srst_n),
    .ev_i     (cause_ev),
    .clr_i    (clr_bits),
    .status_o (status)
  );

  irq_mask_gen #(.STAT_W(STAT_W)) u_irq (
    .clk       (clk),
    .rst_n     (srst_n),
    .mask_we_i (mask_we),
    .mask_d_i  (reg_wdata_i[STAT_W-1:0]),
    .status_i  (status),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (sel == SEL_MASK) reg_rdata_o[STAT_W-1:0] = mask;
    else                 reg_rdata_o[STAT_W-1:0] = status;
  end

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!srst_n)
    reg_rdata_o[DATA_W-1:STAT_W] == '0);
endmodule

// File: tb/sim_irq_cause_top.sv
module sim_irq_cause_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] evt;
  logic        io_acc;
  logic [1:0]  io_addr;
  logic [3:0]  io_be;
  logic        reg_wr;
  logic        reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";
  int    m_stat = 0;
  int    m_mask = 0;
  bit    m_irq  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cause_top u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt),
    .io_acc_i    (io_acc),
    .io_addr_i   (io_addr),
    .io_be_i     (io_be),
    .reg_wr_i    (reg_wr),
    .reg_sel_i   (reg_sel),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .irq_o       (irq)
  );

  function automatic bit be_legal(int a, int be);
    if (a == 0) return 1;
    return ((be >> a) & 1) == 1 && (be & ((1 << a) - 1)) == 0;
  endfunction

  task automatic check(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Call right after a falling edge. Compare, then let one rising edge pass.
  task automatic cyc(int e, bit acc, int a, int be, bit wr, bit sel, int wd);
    int ev, clr, kept, nxt;
    evt = e[13:0]; io_acc = acc; io_addr = a[1:0]; io_be = be[3:0];
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    #1;
    check("rdata", reg_rdata, sel ? m_mask : m_stat);
    check("irq", irq, m_irq);
    ev = e & 'h3FFF;
    if (acc && !be_legal(a, be)) ev |= 1 << 14;
    clr  = (wr && !sel) ? (wd & 'h7FFF) : 0;
    kept = m_stat & ~clr;
    nxt  = kept;
    if (kept == 0 && ev != 0) begin
      for (int k = 0; k < 15; k++) begin
        if (((ev >> k) & 1) == 1) begin
          nxt = 1 << k;
          break;
        end
      end
    end
    m_irq = (m_stat & m_mask) != 0;
    if (wr && sel) m_mask = wd & 'h7FFF;
    m_stat = nxt;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt = '0; io_acc = 0; io_addr = 0; io_be = 0;
    reg_wr = 0; reg_sel = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; idle(4);
    cyc(0, 0, 0, 0, 0, 1, 0);                    // R1 enable word reads 0
    tag = "R8"; cyc(0, 0, 0, 0, 1, 1, 'hFFFFFFFF); // upper bits ignored
    cyc(0, 0, 0, 0, 0, 1, 0);
    tag = "R11"; cyc(0, 0, 0, 0, 1, 1, 'h5);
    cyc(0, 0, 0, 0, 0, 1, 0);
    tag = "R4"; cyc('h2, 0, 0, 0, 0, 0, 0);      // masked cause 1
    idle(3);
    tag = "R2"; cyc('h1, 0, 0, 0, 0, 0, 0);      // blocked by held cause
    cyc('h3FFF, 1, 1, 0, 0, 0, 0);
    idle(2);
    tag = "R6"; cyc(0, 0, 0, 0, 1, 0, 'h7FFD);   // zero at bit 1 keeps it
    idle(1);
    cyc(0, 0, 0, 0, 1, 0, 'hFFFF0002);
    idle(2);
    tag = "R3"; cyc('hC, 0, 0, 0, 0, 0, 0);      // bits 2,3 -> bit 2
    tag = "R5"; idle(3);
    cyc(0, 0, 0, 0, 1, 0, 'h4);
    idle(3);
    tag = "R3"; cyc('h30, 1, 1, 0, 0, 0, 0);     // bit 4 beats 5 and 14
    idle(1);
    tag = "R7"; cyc('h20, 0, 0, 0, 1, 0, 'h10);  // clear + new cause
    idle(2);
    cyc(0, 0, 0, 0, 1, 0, 'h20);
    tag = "R9";
    for (int be = 0; be < 16; be++) cyc(0, 1, 0, be, 0, 0, 0);
    idle(1);
    tag = "R10";
    cyc(0, 0, 1, 0, 0, 0, 0);                    // not an access
    cyc(0, 1, 2, 'b0100, 0, 0, 0);               // legal
    cyc(0, 1, 3, 'b1000, 0, 0, 0);               // legal
    cyc(0, 1, 1, 'b1110, 0, 0, 0);               // legal
    idle(1);
    cyc(0, 1, 2, 'b0110, 0, 0, 0);               // lower lane on
    idle(2);
    tag = "R11"; cyc(0, 0, 0, 0, 1, 1, 'h4000);
    tag = "R5"; idle(3);
    cyc(0, 0, 0, 0, 1, 0, 'h4000);
    tag = "R10";
    cyc(0, 1, 3, 'b0111, 0, 0, 0);               // addressed lane off
    idle(2);
    cyc(0, 0, 0, 0, 1, 0, 'h4000);
    cyc(0, 1, 1, 'b0000, 0, 0, 0);
    idle(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule